// File: doc/BRIEF.md
# Waveform Sampler Trigger Sequencer

This block is the digital sequencer for a multi-channel switched-capacitor waveform recorder. After reset it runs a write phase. In this phase the sample-enable output stays high, and the analog storage is overwritten as a ring buffer. An internal write position moves forward by one slot per clock.

A trigger comes either from any of the per-channel threshold discriminators or from an external strobe, as chosen by a mode input. When a trigger is accepted, the block records the write position and waits a programmable number of cycles. It then drops sample-enable, so that samples from before and after the trigger edge are both held. Next it pulses the converter counter clear and runs the ramp for a fixed number of conversion clocks. When the ramp ends, it raises data-ready and keeps it high until an explicit re-arm starts a new write phase.

The discriminator hits are also copied out, one per channel. A single delayed-trigger pulse marks the moment sampling stops. The analog front end, the ramp and the comparators are outside this block; here they appear only as digital signals.

Top module: `wsq_trigger_seq`

## Requirements
- R1: While reset is applied and right after it, sample_en_o is 1 and data_rdy_o, ramp_run_o, cnt_clr_o and dly_trig_o are 0.
- R2: With trig_mode_i = 0 (self-trigger), a 1 on any bit of disc_hit_i during the write phase is accepted as the trigger, and ext_trig_i has no effect.
- R3: With trig_mode_i = 1 (external), a 1 on ext_trig_i during the write phase is accepted as the trigger, and disc_hit_i has no effect on sampling.
- R4: Let the trigger be sampled at clock edge k, with delay_i = D. Then sample_en_o stays 1 through edge k+D and is 0 after edge k+D+1. With D = 0, sampling stops on the next edge.
- R5: In the first cycle that sample_en_o is 0, cnt_clr_o and dly_trig_o are both 1, each for exactly one cycle.
- R6: ramp_run_o rises in the cycle after the clear pulse and stays 1 for exactly CONV_TICKS cycles (4096 by default).
- R7: data_rdy_o becomes 1 in the cycle after the ramp ends. It is never 1 while sample_en_o or ramp_run_o is 1.
- R8: The write position starts at 0 after reset and advances by one per clock while sample_en_o is 1, wrapping modulo DEPTH. trig_pos_o holds the position seen in the cycle the trigger was sampled.
- R9: Triggers arriving while sampling is already stopping, converting or ready are ignored. The conversion length and trig_pos_o do not change.
- R10: A 1 on rearm_i while data_rdy_o is 1 returns the block to the write phase on the next edge. A 1 on rearm_i at any other time has no effect.
- R11: trig_out_o is disc_hit_i delayed by one clock, per channel, in every phase and mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer and conversion clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_mode_i | input | 1 | 0: discriminator trigger, 1: external trigger |
| ext_trig_i | input | 1 | External trigger strobe |
| disc_hit_i | input | NCH | Per-channel discriminator hits |
| delay_i | input | DLY_W | Post-trigger delay in clock cycles |
| rearm_i | input | 1 | Start a new write phase after readout |
| sample_en_o | output | 1 | 1: track and overwrite, 0: hold all channels |
| cnt_clr_o | output | 1 | One-cycle clear of the converter counters |
| ramp_run_o | output | 1 | Conversion ramp running |
| dly_trig_o | output | 1 | Delayed trigger pulse at the stop instant |
| trig_out_o | output | NCH | Registered copy of the discriminator hits |
| trig_pos_o | output | $clog2(DEPTH) | Write position captured at the trigger |
| data_rdy_o | output | 1 | Conversion finished, data may be read |

## Verification
The checker assumes that the inputs change only between clock edges and that disc_hit_i is 0 while reset is applied. It also assumes that delay_i stays constant from the trigger until sampling stops. The directed stimulus drives every input on the falling edge and clears all hits before it releases reset. It changes the delay setting only during the write phase, before a trigger is applied. Triggers and re-arm strobes are each held high for exactly one cycle, so every transition the properties relate can be traced to one edge.

// File: rtl/wsq_pkg.sv
package wsq_pkg;
   typedef enum logic [2:0] {
      PH_WRITE   = 3'd0,
      PH_DELAY   = 3'd1,
      PH_STOP    = 3'd2,
      PH_CONVERT = 3'd3,
      PH_READY   = 3'd4
   } phase_e;
endpackage

// File: rtl/wsq_trig_select.sv
module wsq_trig_select #(
   parameter int NCH = 4
) (
   input  logic           mode_ext_i,
   input  logic           ext_trig_i,
   input  logic [NCH-1:0] hits_i,
   output logic           fire_o
);
   logic any_hit;

   generate
      if (NCH == 1) begin : g_single
         assign any_hit = hits_i[0];
      end else begin : g_reduce
         assign any_hit = |hits_i;
      end
   endgenerate

   // External mode masks the discriminators; self mode masks the strobe.
   assign fire_o = mode_ext_i ? ext_trig_i : any_hit;
endmodule

// File: rtl/wsq_hit_mirror.sv
module wsq_hit_mirror #(
   parameter int NCH = 4
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NCH-1:0] hits_i,
   output logic [NCH-1:0] hits_q_o
);
   genvar ch;
   generate
      for (ch = 0; ch < NCH; ch++) begin : g_ch
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) hits_q_o[ch] <= 1'b0;
            else        hits_q_o[ch] <= hits_i[ch];
         end
      end
   endgenerate
endmodule

// File: rtl/wsq_write_ptr.sv
module wsq_write_ptr #(
   parameter int DEPTH = 256,
   localparam int PTR_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv_i,
   output logic [PTR_W-1:0] ptr_o
);
   localparam bit POW2 = ((1 << PTR_W) == DEPTH);

   logic [PTR_W-1:0] ptr_next;

   generate
      if (POW2) begin : g_natural_wrap
         assign ptr_next = ptr_o + 1'b1;
      end else begin : g_compare_wrap
         localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
         assign ptr_next = (ptr_o == LAST) ? '0 : ptr_o + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     ptr_o <= '0;
      else if (adv_i) ptr_o <= ptr_next;
   end
endmodule

// File: rtl/wsq_phase_fsm.sv
module wsq_phase_fsm
   import wsq_pkg::*;
#(
   parameter int DLY_W      = 8,
   parameter int CONV_TICKS = 4096
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fire_i,
   input  logic [DLY_W-1:0] delay_i,
   input  logic             rearm_i,
   output phase_e           phase_o,
   output logic             capture_o
);
   localparam int CONV_W = $clog2(CONV_TICKS);
   localparam int CNT_W  = (DLY_W > CONV_W) ? DLY_W : CONV_W;
   localparam logic [CNT_W-1:0] CONV_LOAD = CNT_W'(CONV_TICKS - 1);

   phase_e           phase_q, phase_d;
   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic             cnt_zero;

   assign cnt_zero  = (cnt_q == '0);
   assign capture_o = (phase_q == PH_WRITE) && fire_i;
   assign phase_o   = phase_q;

   always_comb begin
      phase_d = phase_q;
      cnt_d   = cnt_q;
      unique case (phase_q)
         PH_WRITE: begin
            if (fire_i) begin
               phase_d = PH_DELAY;
               cnt_d   = CNT_W'(delay_i);
            end
         end
         PH_DELAY: begin
            if (cnt_zero) phase_d = PH_STOP;
            else          cnt_d   = cnt_q - 1'b1;
         end
         PH_STOP: begin
            phase_d = PH_CONVERT;
            cnt_d   = CONV_LOAD;
         end
         PH_CONVERT: begin
            if (cnt_zero) phase_d = PH_READY;
            else          cnt_d   = cnt_q - 1'b1;
         end
         PH_READY: begin
            if (rearm_i) phase_d = PH_WRITE;
         end
         default: phase_d = PH_WRITE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_WRITE;
         cnt_q   <= '0;
      end else begin
         phase_q <= phase_d;
         cnt_q   <= cnt_d;
      end
   end
endmodule

// File: rtl/wsq_trigger_seq.sv
module wsq_trigger_seq
   import wsq_pkg::*;
#(
   parameter int NCH        = 4,
   parameter int DEPTH      = 256,
   parameter int DLY_W      = 8,
   parameter int CONV_TICKS = 4096,
   localparam int PTR_W     = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             trig_mode_i,
   input  logic             ext_trig_i,
   input  logic [NCH-1:0]   disc_hit_i,
   input  logic [DLY_W-1:0] delay_i,
   input  logic             rearm_i,
   output logic             sample_en_o,
   output logic             cnt_clr_o,
   output logic             ramp_run_o,
   output logic             dly_trig_o,
   output logic [NCH-1:0]   trig_out_o,
   output logic [PTR_W-1:0] trig_pos_o,
   output logic             data_rdy_o
);
   generate
      if (NCH < 1)        begin : g_bad_nch   $error("NCH must be at least 1");        end
      if (DEPTH < 2)      begin : g_bad_depth $error("DEPTH must be at least 2");      end
      if (DLY_W < 1)      begin : g_bad_dly   $error("DLY_W must be at least 1");      end
      if (CONV_TICKS < 2) begin : g_bad_conv  $error("CONV_TICKS must be at least 2"); end
   endgenerate

   phase_e           phase;
   logic             fire;
   logic             capture;
   logic [PTR_W-1:0] wr_ptr;

   wsq_trig_select #(.NCH(NCH)) i_sel (
      .mode_ext_i (trig_mode_i),
      .ext_trig_i (ext_trig_i),
      .hits_i     (disc_hit_i),
      .fire_o     (fire)
   );

   wsq_hit_mirror #(.NCH(NCH)) i_mirror (
      .clk      (clk),
      .rst_n    (rst_n),
      .hits_i   (disc_hit_i),
      .hits_q_o (trig_out_o)
   );

   wsq_phase_fsm #(.DLY_W(DLY_W), .CONV_TICKS(CONV_TICKS)) i_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .fire_i    (fire),
      .delay_i   (delay_i),
      .rearm_i   (rearm_i),
      .phase_o   (phase),
      .capture_o (capture)
   );

   wsq_write_ptr #(.DEPTH(DEPTH)) i_ptr (
      .clk   (clk),
      .rst_n (rst_n),
      .adv_i (sample_en_o),
      .ptr_o (wr_ptr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       trig_pos_o <= '0;
      else if (capture) trig_pos_o <= wr_ptr;
   end

   assign sample_en_o = (phase == PH_WRITE) || (phase == PH_DELAY);
   assign cnt_clr_o   = (phase == PH_STOP);
   assign dly_trig_o  = (phase == PH_STOP);
   assign ramp_run_o  = (phase == PH_CONVERT);
   assign data_rdy_o  = (phase == PH_READY);
endmodule

// File: rtl/wsq_trigger_seq_chk.sv
module wsq_trigger_seq_chk #(
   parameter int NCH   = 4,
   parameter int PTR_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             rearm_i,
   input logic [NCH-1:0]   disc_hit_i,
   input logic             sample_en_o,
   input logic             cnt_clr_o,
   input logic             ramp_run_o,
   input logic             dly_trig_o,
   input logic [NCH-1:0]   trig_out_o,
   input logic [PTR_W-1:0] trig_pos_o,
   input logic             data_rdy_o
);
   logic past_ok;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) past_ok <= 1'b0;
      else        past_ok <= 1'b1;
   end

   p_stop_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && $fell(sample_en_o)) |-> (cnt_clr_o && dly_trig_o));

   p_clear_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_clr_o |=> (!cnt_clr_o && !dly_trig_o));

   p_ramp_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_clr_o |=> ramp_run_o);

   p_ready_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
      data_rdy_o |-> (!sample_en_o && !ramp_run_o));

   p_pos_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && !sample_en_o) |=> $stable(trig_pos_o));

   p_rearm_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (data_rdy_o && rearm_i) |=> (sample_en_o && !data_rdy_o));

   p_mirror_r11: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok |-> (trig_out_o == $past(disc_hit_i)));
endmodule

bind wsq_trigger_seq wsq_trigger_seq_chk #(.NCH(NCH), .PTR_W(PTR_W)) i_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .rearm_i     (rearm_i),
   .disc_hit_i  (disc_hit_i),
   .sample_en_o (sample_en_o),
   .cnt_clr_o   (cnt_clr_o),
   .ramp_run_o  (ramp_run_o),
   .dly_trig_o  (dly_trig_o),
   .trig_out_o  (trig_out_o),
   .trig_pos_o  (trig_pos_o),
   .data_rdy_o  (data_rdy_o)
);

// File: tb/test_wsq_trigger_seq.sv
`timescale 1ns/1ps
module test_wsq_trigger_seq;
   localparam int NCH   = 4;
   localparam int DEPTH = 256;
   localparam int DLY_W = 8;
   localparam int CONV  = 4096;
   localparam int PTR_W = $clog2(DEPTH);

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             trig_mode_i = 1'b0;
   logic             ext_trig_i = 1'b0;
   logic [NCH-1:0]   disc_hit_i = '0;
   logic [DLY_W-1:0] delay_i = '0;
   logic             rearm_i = 1'b0;
   logic             sample_en_o, cnt_clr_o, ramp_run_o, dly_trig_o, data_rdy_o;
   logic [NCH-1:0]   trig_out_o;
   logic [PTR_W-1:0] trig_pos_o;

   int checks = 0;
   int errors = 0;
   logic [PTR_W-1:0] exp_ptr;

   always #2.5 clk = ~clk;

   wsq_trigger_seq #(.NCH(NCH), .DEPTH(DEPTH), .DLY_W(DLY_W), .CONV_TICKS(CONV)) i_wsq_trigger_seq (
      .clk(clk), .rst_n(rst_n), .trig_mode_i(trig_mode_i), .ext_trig_i(ext_trig_i),
      .disc_hit_i(disc_hit_i), .delay_i(delay_i), .rearm_i(rearm_i),
      .sample_en_o(sample_en_o), .cnt_clr_o(cnt_clr_o), .ramp_run_o(ramp_run_o),
      .dly_trig_o(dly_trig_o), .trig_out_o(trig_out_o), .trig_pos_o(trig_pos_o),
      .data_rdy_o(data_rdy_o)
   );

   // Write-position model (R8): +1 per edge while sampling, from 0 at reset.
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n)           exp_ptr <= '0;
      else if (sample_en_o) exp_ptr <= exp_ptr + 1'b1;
   end

   task automatic check(input string req, input longint act, input longint exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // Trigger, then measure delay, clear, ramp, ready and captured position.
   // disturb: inject triggers/rearm during conversion (R9, R10).
   task automatic capture_cycle(input bit mode, input bit use_ext, input logic [NCH-1:0] hits,
                                input int d, input bit disturb, input string tag);
      logic [PTR_W-1:0] want_pos;
      int n_high, n_ramp;
      @(negedge clk);
      trig_mode_i = mode;
      delay_i = DLY_W'(d);
      if (use_ext) ext_trig_i = 1'b1; else disc_hit_i = hits;
      want_pos = exp_ptr;
      @(negedge clk);
      ext_trig_i = 1'b0;
      disc_hit_i = '0;
      n_high = 0;
      while (sample_en_o && n_high < 300) begin n_high++; @(negedge clk); end
      check({"R4 sample window ", tag}, n_high, d + 1);
      check({"R5 clear pulse ", tag}, {cnt_clr_o, dly_trig_o}, 2'b11);
      @(negedge clk);
      check({"R5 clear single ", tag}, {cnt_clr_o, dly_trig_o}, 2'b00);
      n_ramp = 0;
      while (ramp_run_o && n_ramp < CONV + 10) begin
         if (disturb && n_ramp == 3) begin
            ext_trig_i = 1'b1; disc_hit_i = '1; rearm_i = 1'b1;
         end else begin
            ext_trig_i = 1'b0; disc_hit_i = '0; rearm_i = 1'b0;
         end
         n_ramp++;
         @(negedge clk);
      end
      check({"R6 ramp length ", tag}, n_ramp, CONV);
      check({"R7 ready after ramp ", tag}, data_rdy_o, 1);
      check({"R8 trigger position ", tag}, trig_pos_o, want_pos);
      if (disturb) begin
         ext_trig_i = 1'b1; disc_hit_i = '1;
         @(negedge clk);
         ext_trig_i = 1'b0; disc_hit_i = '0;
         idle(2);
         check("R9 late trigger ignored, ready held", data_rdy_o, 1);
         check("R9 late trigger, position unchanged", trig_pos_o, want_pos);
      end
   endtask

   task automatic rearm_now();
      rearm_i = 1'b1;
      @(negedge clk);
      rearm_i = 1'b0;
      check("R10 rearm restarts sampling", {sample_en_o, data_rdy_o}, 2'b10);
   endtask

   task automatic t_reset();
      idle(1);
      check("R1 reset outputs", {sample_en_o, data_rdy_o, ramp_run_o, cnt_clr_o, dly_trig_o}, 5'b10000);
      rst_n = 1'b1;
      idle(1);
      check("R1 after release", {sample_en_o, data_rdy_o, ramp_run_o, cnt_clr_o, dly_trig_o}, 5'b10000);
   endtask

   task automatic t_masked_sources();
      // R2: external strobe ignored in self mode.
      trig_mode_i = 1'b0; ext_trig_i = 1'b1;
      @(negedge clk); ext_trig_i = 1'b0;
      idle(3);
      check("R2 ext ignored in self mode", sample_en_o, 1);
      // R3: hits ignored in external mode.
      trig_mode_i = 1'b1; disc_hit_i = 4'b1001;
      @(negedge clk); disc_hit_i = '0;
      idle(3);
      check("R3 hits ignored in external mode", sample_en_o, 1);
      check("R3 no ready without trigger", data_rdy_o, 0);
   endtask

   task automatic t_rearm_early();
      // R10: rearm during write phase does nothing.
      rearm_i = 1'b1;
      @(negedge clk); rearm_i = 1'b0;
      check("R10 rearm ignored while writing", {sample_en_o, data_rdy_o}, 2'b10);
   endtask

   task automatic t_mirror();
      disc_hit_i = 4'b0101;
      @(negedge clk);
      check("R11 hit mirror", trig_out_o, 4'b0101);
      disc_hit_i = 4'b1010;
      @(negedge clk);
      disc_hit_i = '0;
      check("R11 hit mirror next", trig_out_o, 4'b1010);
      @(negedge clk);
      check("R11 hit mirror clear", trig_out_o, 4'b0000);
   endtask

   initial begin
      #(200000 * 5.0);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      t_reset();
      idle(5);
      t_masked_sources();
      t_rearm_early();
      t_mirror();
      capture_cycle(1'b0, 1'b0, 4'b0100, 3, 1'b0, "self ch2 D=3");
      t_mirror();                           // R11 in ready phase
      rearm_now();
      capture_cycle(1'b1, 1'b1, '0, 0, 1'b1, "ext D=0");
      rearm_now();
      idle(300);                            // let position wrap (R8)
      capture_cycle(1'b0, 1'b0, 4'b0001, 255, 1'b0, "self ch0 D=255");
      rearm_now();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule